// File: doc/BRIEF.md
# Byte-Port Bridge to Engine Register Files and Program Memory

This block connects a narrow 8-bit on-chip bus to the 32-bit storage of two embedded processing engines. Software stages a 32-bit word in four byte-wide data ports and an address in an address port. It picks the target engine with a select port, then writes an operation code into a command port. The bridge then presents one request to the chosen engine's memory-style port. A write moves the staged word into the engine. A read returns a 32-bit word that is loaded into the four data ports. The START status bit in the command port stays high for the whole transfer, and software polls it to learn when the transfer has finished.

Each engine has a 128-word register file and a 512-word program memory. A register access takes a 7-bit address from the address port. A program access builds a 9-bit address: the address byte supplies the low eight bits and bit 3 of the command byte supplies the top bit. A device-lock input blocks all engine traffic. A command written while the lock is high is discarded and sets a sticky violation flag.

Top module: `eng_access_bridge`

## Requirements
- R1: After reset the four data ports, the START bit and the select bit all read 0.
- R2: The bus offsets are fixed. Offsets 0 to 3 are the data bytes, with offset 0 holding bits 7:0 and offset 3 holding bits 31:24. Offset 4 is the address port, which can be written but always reads 0. Offset 5 is the command port, which reads START in bit 0 and 0 in bits 7:1. Offset 6 is the select port, which reads the select value in bit 0 and 0 in bits 7:1. Offset 7 reads 0.
- R3: Bits 2:0 of a command write give the operation: 1 is a register write, 2 is a register read, 3 is a program write and 4 is a program read. When a valid code is written while the lock is low and the bridge is idle, START reads 1 from the next cycle on.
- R4: A register access sends address-port bits 6:0 to the engine, with engine address bits 8:7 at 0, so address-port bit 7 has no effect on it.
- R5: A program access sends the 9-bit address {command bit 3, address port}.
- R6: With select 0, only engine 0 is requested. With select 1, only engine 1 is requested. At most one request is high at any time, and the other engine's contents are never touched.
- R7: START clears in the cycle after the selected engine acknowledges. On a read, the acknowledged 32-bit word appears in the data ports at the same edge.
- R8: While START is 1, writes to the data, address, command and select ports are ignored.
- R9: Command codes 0, 5, 6 and 7 are ignored: START stays 0 and no request is issued.
- R10: While the lock is high, no engine request is driven, and a transfer already in progress waits until the lock drops. A valid command written while the lock is high is discarded and leaves START at 0. It also sets the lock-violation flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Bus port offset |
| busWe | input | 1 | Bus write strobe, one byte per cycle |
| busWdata | input | 8 | Bus write byte |
| busRdata | output | 8 | Read byte for the port at busAddr (combinational) |
| lockIn | input | 1 | Device lock; blocks all engine access |
| lockViol | output | 1 | Sticky flag: a command was written while locked |
| engReq | output | 2 | Per-engine request, held until acknowledged |
| engWrite | output | 1 | 1 = write transfer, 0 = read transfer |
| engProg | output | 1 | 1 = program memory, 0 = register file |
| engAddr | output | 9 | Engine word address |
| engWdata | output | 32 | Word to write |
| engAck | input | 2 | Per-engine one-cycle acknowledge |
| engRdata | input | 64 | Read words, engine 0 in bits 31:0 |

## Verification
The assertions assume three things about the engines. Each engine raises its acknowledge only while its own request is high. The acknowledge lasts a single cycle. Read data is valid in that same cycle. The bench engine model follows these rules: it waits a random 0 to 3 cycles after it sees a request, pulses the acknowledge once, and stays quiet while its request is low. Bus stimulus changes only away from the rising edge. Random transfers cover both engines, all four operation codes and random addresses, including register addresses with bit 7 set. A stall switch on the model holds a transfer open so that the busy-window writes and the lock cases can be exercised.

// File: rtl/eab_pkg.sv
package eab_pkg;
  localparam int DATA_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = DATA_W / BYTE_W;
  localparam int REG_AW    = 7;
  localparam int PROG_AW   = 9;
  localparam int PORT_AW   = 3;

  localparam logic [PORT_AW-1:0] P_ADDR = 3'd4;
  localparam logic [PORT_AW-1:0] P_CMD  = 3'd5;
  localparam logic [PORT_AW-1:0] P_SEL  = 3'd6;

  localparam logic [2:0] OP_NONE    = 3'd0;
  localparam logic [2:0] OP_REG_WR  = 3'd1;
  localparam logic [2:0] OP_REG_RD  = 3'd2;
  localparam logic [2:0] OP_PROG_WR = 3'd3;
  localparam logic [2:0] OP_PROG_RD = 3'd4;

  typedef struct packed {
    logic [NUM_BYTES-1:0] dataWr;
    logic                 addrWr;
    logic                 selWr;
    logic                 cmdAccept;
    logic                 progHi;
    logic                 loadRd;
  } strobe_t;
endpackage

// File: rtl/eab_ctrl.sv
module eab_ctrl
  import eab_pkg::*;
#(
  parameter int NUM_ENG = 2
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         busWe,
  input  logic [PORT_AW-1:0]                           busAddr,
  input  logic [3:0]                                   cmdBits,
  input  logic                                         lockIn,
  input  logic [NUM_ENG-1:0]                           engAck,
  input  logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] selQ,
  output strobe_t                                      strb,
  output logic                                         busy,
  output logic                                         engWrite,
  output logic                                         engProg,
  output logic [NUM_ENG-1:0]                           engReq,
  output logic                                         lockViol
);
  localparam int SEL_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

  logic [2:0] opQ;
  logic       cmdWrite;
  logic       validOp;
  logic       accept;
  logic       done;
  logic       isRead;

  assign cmdWrite = busWe && (busAddr == P_CMD) && !busy;
  assign validOp  = (cmdBits[2:0] >= OP_REG_WR) && (cmdBits[2:0] <= OP_PROG_RD);
  assign accept   = cmdWrite && validOp && !lockIn;
  assign done     = busy && !lockIn && engAck[selQ];

  assign engWrite = (opQ == OP_REG_WR) || (opQ == OP_PROG_WR);
  assign engProg  = (opQ == OP_PROG_WR) || (opQ == OP_PROG_RD);
  assign isRead   = !engWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      opQ      <= OP_NONE;
      lockViol <= 1'b0;
    end else begin
      if (accept) begin
        busy <= 1'b1;
        opQ  <= cmdBits[2:0];
      end else if (done) begin
        busy <= 1'b0;
      end
      if (cmdWrite && validOp && lockIn) lockViol <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_dataStrb
    assign strb.dataWr[b] = busWe && !busy && (busAddr == PORT_AW'(b));
  end
  assign strb.addrWr    = busWe && !busy && (busAddr == P_ADDR);
  assign strb.selWr     = busWe && !busy && (busAddr == P_SEL);
  assign strb.cmdAccept = accept;
  assign strb.progHi    = cmdBits[3];
  assign strb.loadRd    = done && isRead;

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_req
    assign engReq[g] = busy && !lockIn && (selQ == SEL_W'(g));
  end

  // R6
  onehot_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(engReq));
  // R10
  lock_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |-> (engReq == '0));
  // R10
  sticky_viol_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockViol |=> lockViol);
  // R9
  bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == P_CMD && !busy &&
     (cmdBits[2:0] == 3'd0 || cmdBits[2:0] > 3'd4)) |=> !busy);
  // R3
  start_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == P_CMD && !busy && !lockIn &&
     cmdBits[2:0] != 3'd0 && cmdBits[2:0] <= 3'd4) |=> busy);
  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(engReq & engAck)) |=> !busy);
endmodule

// File: rtl/eab_datapath.sv
module eab_datapath
  import eab_pkg::*;
#(
  parameter int NUM_ENG = 2
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  strobe_t                                      strb,
  input  logic                                         busy,
  input  logic                                         engProg,
  input  logic [PORT_AW-1:0]                           busAddr,
  input  logic [BYTE_W-1:0]                            busWdata,
  input  logic [NUM_ENG*DATA_W-1:0]                    engRdata,
  output logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] selQ,
  output logic [BYTE_W-1:0]                            busRdata,
  output logic [PROG_AW-1:0]                           engAddr,
  output logic [DATA_W-1:0]                            engWdata
);
  localparam int SEL_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

  logic [NUM_BYTES-1:0][BYTE_W-1:0] dataQ;
  logic [BYTE_W-1:0]                addrQ;
  logic                             progHiQ;
  logic [DATA_W-1:0]                rdWord;

  assign rdWord = engRdata[selQ*DATA_W +: DATA_W];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_dataByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                dataQ[b] <= '0;
      else if (strb.loadRd)     dataQ[b] <= rdWord[b*BYTE_W +: BYTE_W];
      else if (strb.dataWr[b])  dataQ[b] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      selQ    <= '0;
      progHiQ <= 1'b0;
    end else begin
      if (strb.addrWr)    addrQ   <= busWdata;
      if (strb.selWr)     selQ    <= busWdata[SEL_W-1:0];
      if (strb.cmdAccept) progHiQ <= strb.progHi;
    end
  end

  assign engWdata = dataQ;
  assign engAddr  = engProg ? {progHiQ, addrQ}
                            : {{(PROG_AW-REG_AW){1'b0}}, addrQ[REG_AW-1:0]};

  always_comb begin
    busRdata = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (busAddr == PORT_AW'(b)) busRdata = dataQ[b];
    end
    if (busAddr == P_CMD) busRdata = {{(BYTE_W-1){1'b0}}, busy};
    if (busAddr == P_SEL) busRdata = {{(BYTE_W-SEL_W){1'b0}}, selQ};
  end

  // R8
  held_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.loadRd) |=> ($stable(dataQ) && $stable(addrQ) && $stable(selQ)));
  // R4
  reg_addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !engProg) |-> (engAddr[PROG_AW-1:REG_AW] == '0));
endmodule

// File: rtl/eng_access_bridge.sv
module eng_access_bridge
  import eab_pkg::*;
#(
  parameter int NUM_ENG = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PORT_AW-1:0]        busAddr,
  input  logic                      busWe,
  input  logic [BYTE_W-1:0]         busWdata,
  output logic [BYTE_W-1:0]         busRdata,
  input  logic                      lockIn,
  output logic                      lockViol,
  output logic [NUM_ENG-1:0]        engReq,
  output logic                      engWrite,
  output logic                      engProg,
  output logic [PROG_AW-1:0]        engAddr,
  output logic [DATA_W-1:0]         engWdata,
  input  logic [NUM_ENG-1:0]        engAck,
  input  logic [NUM_ENG*DATA_W-1:0] engRdata
);
  localparam int SEL_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

  strobe_t          strb;
  logic             busy;
  logic [SEL_W-1:0] selQ;

  eab_ctrl #(.NUM_ENG(NUM_ENG)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .cmdBits(busWdata[3:0]), .lockIn(lockIn), .engAck(engAck), .selQ(selQ),
    .strb(strb), .busy(busy), .engWrite(engWrite), .engProg(engProg),
    .engReq(engReq), .lockViol(lockViol)
  );

  eab_datapath #(.NUM_ENG(NUM_ENG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .engProg(engProg),
    .busAddr(busAddr), .busWdata(busWdata), .engRdata(engRdata),
    .selQ(selQ), .busRdata(busRdata), .engAddr(engAddr), .engWdata(engWdata)
  );
endmodule

// File: tb/eng_access_bridge_bench.sv
module eng_access_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        lockIn = 1'b0;
  logic        lockViol;
  logic [1:0]  engReq;
  logic        engWrite, engProg;
  logic [8:0]  engAddr;
  logic [31:0] engWdata;
  logic [1:0]  engAck = '0;
  logic [63:0] engRdata = '0;

  int nChecks = 0;
  int nFails  = 0;
  int badAddr = 0;
  int bothReq = 0;
  bit stall   = 1'b0;
  int dly [2] = '{0, 0};

  logic [31:0] modelReg  [2][128];
  logic [31:0] modelProg [2][512];
  logic [31:0] shReg     [2][128];
  logic [31:0] shProg    [2][512];

  always #4 clk = ~clk;

  eng_access_bridge u_eng_access_bridge (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .lockIn(lockIn),
    .lockViol(lockViol), .engReq(engReq), .engWrite(engWrite),
    .engProg(engProg), .engAddr(engAddr), .engWdata(engWdata),
    .engAck(engAck), .engRdata(engRdata)
  );

  function automatic logic [31:0] initWord(int e, int prog, int a);
    return 32'hA500_0000 ^ (e << 20) ^ (prog << 16) ^ a;
  endfunction

  // Engine model: random latency, single-cycle acknowledge
  always @(negedge clk) begin
    if (engReq == 2'b11) bothReq++;
    for (int e = 0; e < 2; e++) begin
      if (engAck[e]) engAck[e] = 1'b0;
      else if (engReq[e] && !stall) begin
        if (dly[e] == 0) begin
          if (!engProg && engAddr[8:7] != 2'b00) badAddr++;
          if (engWrite) begin
            if (engProg) modelProg[e][engAddr] = engWdata;
            else         modelReg[e][engAddr[6:0]] = engWdata;
          end
          engRdata[e*32 +: 32] = engProg ? modelProg[e][engAddr] : modelReg[e][engAddr[6:0]];
          engAck[e] = 1'b1;
          dly[e] = $urandom % 4;
        end else dly[e]--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitDone();
    logic [7:0] v;
    for (int i = 0; i < 400; i++) begin
      busRd(3'd5, v);
      if (!v[0]) break;
    end
  endtask

  task automatic readWord(output logic [31:0] w);
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      busRd(3'(i), v);
      w[i*8 +: 8] = v;
    end
  endtask

  task automatic doXfer(input int e, input logic [2:0] op, input logic [8:0] a, input logic [31:0] w);
    logic [7:0]  v;
    logic [31:0] got;
    bit prog, wr;
    int idx;
    prog = (op == 3'd3 || op == 3'd4);
    wr   = (op == 3'd1 || op == 3'd3);
    idx  = prog ? int'(a) : int'(a[6:0]);
    busWr(3'd6, 8'(e));
    busWr(3'd4, a[7:0]);
    if (wr) for (int i = 0; i < 4; i++) busWr(3'(i), w[i*8 +: 8]);
    busWr(3'd5, {4'b0, a[8], op});
    busRd(3'd5, v);
    chk(v == 8'h01, "R3 start high", 32'(v), 32'h1);
    waitDone();
    if (wr) begin
      if (prog) begin
        shProg[e][idx] = w;
        chk(modelProg[e][idx] == w, "R5 prog write", modelProg[e][idx], w);
        chk(modelProg[1-e][idx] == shProg[1-e][idx], "R6 other engine", modelProg[1-e][idx], shProg[1-e][idx]);
      end else begin
        shReg[e][idx] = w;
        chk(modelReg[e][idx] == w, "R4 reg write", modelReg[e][idx], w);
        chk(modelReg[1-e][idx] == shReg[1-e][idx], "R6 other engine", modelReg[1-e][idx], shReg[1-e][idx]);
      end
    end else begin
      readWord(got);
      if (prog) chk(got == shProg[e][idx], "R7 prog read data", got, shProg[e][idx]);
      else      chk(got == shReg[e][idx],  "R7 reg read data",  got, shReg[e][idx]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] got;
    void'($urandom(32'd20251));
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 128; a++) begin
        modelReg[e][a] = initWord(e, 0, a); shReg[e][a] = initWord(e, 0, a);
      end
      for (int a = 0; a < 512; a++) begin
        modelProg[e][a] = initWord(e, 1, a); shProg[e][a] = initWord(e, 1, a);
      end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values, R2 unused offsets
    for (int p = 0; p < 8; p++) begin
      busRd(3'(p), v);
      chk(v == 8'h00, (p == 4 || p == 7) ? "R2 reads zero" : "R1 reset value", 32'(v), 32'h0);
    end

    // R2 readback and port placement
    busWr(3'd0, 8'h11); busWr(3'd1, 8'h22); busWr(3'd2, 8'h33); busWr(3'd3, 8'h44);
    readWord(got);
    chk(got == 32'h4433_2211, "R2 data byte order", got, 32'h4433_2211);
    busWr(3'd4, 8'hFF); busRd(3'd4, v);
    chk(v == 8'h00, "R2 address write-only", 32'(v), 32'h0);
    busWr(3'd6, 8'hFF); busRd(3'd6, v);
    chk(v == 8'h01, "R2 select readback", 32'(v), 32'h1);
    busWr(3'd6, 8'h00);

    // R9 ignored codes
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 4) continue;
      busWr(3'd5, 8'(c));
      busRd(3'd5, v);
      chk(v == 8'h00, "R9 ignored code", 32'(v), 32'h0);
      chk(engReq == 2'b00, "R9 no request", 32'(engReq), 32'h0);
    end

    // R4 directed: address bit 7 set on register access
    doXfer(0, 3'd1, 9'h085, 32'hCAFE_0085);
    doXfer(0, 3'd2, 9'h005, 32'h0);
    // R5 directed: top program address bit
    doXfer(1, 3'd3, 9'h1FF, 32'hBEEF_01FF);
    doXfer(1, 3'd4, 9'h1FF, 32'h0);
    doXfer(1, 3'd4, 9'h0FF, 32'h0);

    // Random mix
    for (int n = 0; n < 80; n++) begin
      int e;
      logic [2:0] op;
      e  = $urandom % 2;
      op = 3'(1 + ($urandom % 4));
      doXfer(e, op, 9'($urandom), 32'($urandom));
    end

    // R8 writes ignored while busy
    stall = 1'b1;
    busWr(3'd6, 8'h00); busWr(3'd4, 8'h10);
    busWr(3'd0, 8'hA1); busWr(3'd1, 8'hB2); busWr(3'd2, 8'hC3); busWr(3'd3, 8'hD4);
    busWr(3'd5, 8'h01);
    busWr(3'd0, 8'hEE); busWr(3'd4, 8'h20); busWr(3'd6, 8'h01); busWr(3'd5, 8'h02);
    busRd(3'd0, v);
    chk(v == 8'hA1, "R8 data held", 32'(v), 32'hA1);
    busRd(3'd6, v);
    chk(v == 8'h00, "R8 select held", 32'(v), 32'h0);
    chk(engReq == 2'b01 && engWrite, "R8 command held", {30'b0, engReq}, 32'h1);
    stall = 1'b0;
    waitDone();
    shReg[0][16] = 32'hD4C3_B2A1;
    chk(modelReg[0][16] == 32'hD4C3_B2A1, "R8 staged word written", modelReg[0][16], 32'hD4C3_B2A1);
    chk(modelReg[0][32] == shReg[0][32], "R8 address held", modelReg[0][32], shReg[0][32]);
    chk(modelReg[1][16] == shReg[1][16], "R8 select held engine1", modelReg[1][16], shReg[1][16]);

    // R10 command while locked
    lockIn = 1'b1;
    busWr(3'd5, 8'h02);
    busRd(3'd5, v);
    chk(v == 8'h00, "R10 locked command discarded", 32'(v), 32'h0);
    chk(lockViol == 1'b1, "R10 violation flag", 32'(lockViol), 32'h1);
    chk(engReq == 2'b00, "R10 no request locked", 32'(engReq), 32'h0);
    lockIn = 1'b0;

    // R10 lock during transfer
    stall = 1'b1;
    busWr(3'd6, 8'h01); busWr(3'd4, 8'h07);
    busWr(3'd5, 8'h02);
    lockIn = 1'b1;
    stall  = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk(engReq == 2'b00, "R10 request withheld", 32'(engReq), 32'h0);
    busRd(3'd5, v);
    chk(v == 8'h01, "R10 transfer pending", 32'(v), 32'h1);
    lockIn = 1'b0;
    waitDone();
    readWord(got);
    chk(got == shReg[1][7], "R10 resumed read", got, shReg[1][7]);
    chk(lockViol == 1'b1, "R10 flag sticky", 32'(lockViol), 32'h1);

    chk(badAddr == 0, "R4 register address upper bits", 32'(badAddr), 32'h0);
    chk(bothReq == 0, "R6 single request", 32'(bothReq), 32'h0);

    summary();
    $finish;
  end
endmodule